// File: doc/BRIEF.md
# MDIO Paged Register Access Bridge

This block is the managed side of a clause-22 MDIO link. It opens a 32-bit internal register space, with an 18-bit byte address, to an external station manager that can only move 16 bits per frame. A page register at its own PHY address holds the upper address bits. Eight consecutive PHY addresses, together with the register number of each frame, select one 32-bit word inside the current page and one 16-bit half of that word.

On the internal side the bridge masters a simple register bus. It drives an address, write data, a one-cycle write strobe and a one-cycle read strobe. A write is assembled from two frames: the upper half is parked, and the lower half triggers the bus write. A read is fetched in full when the lower half is requested. The upper half is then served from a latch, so both halves belong to the same fetch. Word address 0 is a read-only identification word that the bridge answers by itself.

MDC is oversampled by the system clock. Its half-period must be at least 6 system clock cycles.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset, mdio_oe, bus_we and bus_re are low and the page register is 0.
- R2: A frame is decoded only after at least 32 consecutive ones followed by the start pattern 0,1. A frame preceded by 31 ones has no effect. A longer run of ones is accepted.
- R3: A write frame (opcode 01) to PHY address 0x18, register 0, loads the low 9 bits of its data into the page register. A read frame (opcode 10) to the same place returns the page, zero-extended to 16 bits.
- R4: A data frame at PHY address 0x10+k (k = 0..7), register number r, targets byte address {page[8:0], k[2:0], r[4:1], 2'b00}. An even r selects data bits [15:0] and an odd r selects bits [31:16].
- R5: A write to an odd register only stores the upper half and raises no strobe. A write to an even register raises bus_we for exactly one cycle, with bus_wdata = {stored upper half, new lower half}.
- R6: A read of an even register raises bus_re exactly once and returns bus_rdata[15:0]. A following read of the odd register returns bus_rdata[31:16] from that same fetch and raises no strobe.
- R7: Reads of word address 0 return 0x0101 (revision 1 in bits [7:0], device 1 in bits [15:8]) for the lower half and 0x0000 for the upper half, without raising bus_re.
- R8: In a read frame the bridge leaves the line undriven for the first turnaround bit, drives 0 for the second, then drives 16 data bits MSB first, and releases the line after the last data bit.
- R9: Frames to any other PHY address, frames to PHY 0x18 with a nonzero register, and frames with opcode 00 or 11 leave the line undriven, raise no strobe and leave the page unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples MDC |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Sampled state of the shared data line |
| mdio_o | output | 1 | Data value driven while mdio_oe is high |
| mdio_oe | output | 1 | Output enable for the data line |
| bus_addr | output | 18 | Internal byte address |
| bus_wdata | output | 32 | Internal write data |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe |
| bus_rdata | input | 32 | Read data, valid in the cycle after bus_re |

## Verification
Every result is tied to an MDC rising edge, plus a two-flop synchronizer and one register stage.

- Bus strobes appear about four system clocks after the edge that completes the header (for reads) or the final data bit (for writes).
- Each driven read bit appears about four clocks after the edge that precedes its bit period.

The bench holds each MDC phase for eight clocks and samples the line on the last clock before each rising edge, which is where a station manager would sample it. Strobe counts and captured bus values are compared only after a frame has fully ended, when all these delays have elapsed.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PAGE = 2'd1,
    ACC_DATA = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_HDR   = 2'd2,
    RX_BODY  = 2'd3
  } rx_state_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam int HDR_BITS  = 12;  // opcode, phy address, register number
  localparam int BODY_BITS = 18;  // turnaround plus 16 data bits
endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_bridge_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mdc,
  input  logic        mdio_i,
  input  logic        accept,
  input  logic [15:0] rd_word16,
  output logic [1:0]  hdr_op,
  output logic [4:0]  hdr_phy,
  output logic [4:0]  hdr_reg,
  output logic        hdr_stb,
  output logic        wr_stb,
  output logic [15:0] wr_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int ONES_W = $clog2(PRE_LEN + 1);
  localparam int CNT_W  = $clog2(BODY_BITS + 1);

  logic [2:0]          mdc_q;
  logic [1:0]          dio_q;
  logic                tick;
  logic                din;
  rx_state_e           st;
  logic [ONES_W-1:0]   ones;
  logic [CNT_W-1:0]    cnt;
  logic [HDR_BITS-1:0] hdr_sr;
  logic [15:0]         body_sr;
  logic [16:0]         tx;
  logic                rd_frame;

  assign tick     = mdc_q[1] & ~mdc_q[2];
  assign din      = dio_q[1];
  assign hdr_op   = hdr_sr[11:10];
  assign hdr_phy  = hdr_sr[9:5];
  assign hdr_reg  = hdr_sr[4:0];
  assign wr_data  = body_sr;
  assign mdio_o   = tx[16];
  assign rd_frame = (hdr_op == OPC_READ) && accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_q <= '0;
      dio_q <= '1;
    end else begin
      mdc_q <= {mdc_q[1:0], mdc};
      dio_q <= {dio_q[0], mdio_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RX_IDLE;
      ones    <= '0;
      cnt     <= '0;
      hdr_sr  <= '0;
      body_sr <= '0;
      hdr_stb <= 1'b0;
      wr_stb  <= 1'b0;
      mdio_oe <= 1'b0;
      tx      <= '0;
    end else begin
      hdr_stb <= 1'b0;
      wr_stb  <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: begin
            if (din) begin
              if (ones != ONES_W'(PRE_LEN)) ones <= ones + 1'b1;
            end else begin
              if (ones == ONES_W'(PRE_LEN)) st <= RX_START;
              ones <= '0;
            end
          end
          RX_START: begin
            st  <= din ? RX_HDR : RX_IDLE;
            cnt <= '0;
          end
          RX_HDR: begin
            hdr_sr <= {hdr_sr[HDR_BITS-2:0], din};
            cnt    <= cnt + 1'b1;
            if (cnt == CNT_W'(HDR_BITS - 1)) begin
              st      <= RX_BODY;
              cnt     <= '0;
              hdr_stb <= 1'b1;
            end
          end
          default: begin
            body_sr <= {body_sr[14:0], din};
            cnt     <= cnt + 1'b1;
            if (rd_frame) begin
              if (cnt == '0) begin
                mdio_oe <= 1'b1;
                tx      <= {1'b0, rd_word16};
              end else if (cnt == CNT_W'(BODY_BITS - 1)) begin
                mdio_oe <= 1'b0;
              end else begin
                tx <= {tx[15:0], 1'b0};
              end
            end
            if (cnt == CNT_W'(BODY_BITS - 1)) begin
              st     <= RX_IDLE;
              cnt    <= '0;
              ones   <= '0;
              wr_stb <= (hdr_op == OPC_WRITE);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_addr_map.sv
module mdio_addr_map
  import mdio_bridge_pkg::*;
#(
  parameter int          PAGE_W   = 9,
  parameter logic [4:0]  PHY_BASE = 5'h10,
  parameter logic [4:0]  PAGE_PHY = 5'h18
) (
  input  logic [1:0]        op,
  input  logic [4:0]        phy,
  input  logic [4:0]        regn,
  input  logic [PAGE_W-1:0] page,
  output acc_kind_e         kind,
  output logic              half,
  output logic              accept,
  output logic [PAGE_W+8:0] addr
);
  logic op_ok;

  assign op_ok  = (op == OPC_READ) || (op == OPC_WRITE);
  assign half   = regn[0];
  assign addr   = {page, phy[2:0], regn[4:1], 2'b00};
  assign accept = (kind != ACC_NONE);

  always_comb begin
    kind = ACC_NONE;
    if (op_ok) begin
      if (phy == PAGE_PHY) begin
        if (regn == 5'd0) kind = ACC_PAGE;
      end else if (phy[4:3] == PHY_BASE[4:3]) begin
        kind = ACC_DATA;
      end
    end
  end
endmodule

// File: rtl/mdio_word_engine.sv
module mdio_word_engine
  import mdio_bridge_pkg::*;
#(
  parameter int          PAGE_W   = 9,
  parameter logic [31:0] ID_VALUE = 32'h0000_0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_stb,
  input  logic              wr_stb,
  input  logic [1:0]        hdr_op,
  input  acc_kind_e         kind,
  input  logic              half,
  input  logic [PAGE_W+8:0] addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_word16,
  output logic [PAGE_W-1:0] page,
  output logic [PAGE_W+8:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [31:0]       bus_rdata
);
  logic [15:0] wr_hold;
  logic [15:0] rd_hold;
  logic        cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word16 <= '0;
      page      <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      wr_hold   <= '0;
      rd_hold   <= '0;
      cap       <= 1'b0;
    end else begin
      bus_we <= 1'b0;
      bus_re <= 1'b0;
      cap    <= bus_re;
      if (cap) begin
        rd_word16 <= bus_rdata[15:0];
        rd_hold   <= bus_rdata[31:16];
      end
      if (hdr_stb && hdr_op == OPC_READ) begin
        case (kind)
          ACC_PAGE: rd_word16 <= 16'(page);
          ACC_DATA: begin
            if (half) begin
              rd_word16 <= rd_hold;
            end else if (addr == '0) begin
              rd_word16 <= ID_VALUE[15:0];
              rd_hold   <= ID_VALUE[31:16];
            end else begin
              bus_re   <= 1'b1;
              bus_addr <= addr;
            end
          end
          default: ;
        endcase
      end
      if (wr_stb) begin
        case (kind)
          ACC_PAGE: page <= wr_data[PAGE_W-1:0];
          ACC_DATA: begin
            if (half) begin
              wr_hold <= wr_data;
            end else begin
              bus_we    <= 1'b1;
              bus_addr  <= addr;
              bus_wdata <= {wr_hold, wr_data};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int          PAGE_W   = 9,
  parameter logic [4:0]  PHY_BASE = 5'h10,
  parameter logic [4:0]  PAGE_PHY = 5'h18,
  parameter int          PRE_LEN  = 32,
  parameter logic [31:0] ID_VALUE = 32'h0000_0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [PAGE_W+8:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [31:0]       bus_rdata
);
  logic [1:0]        hdr_op;
  logic [4:0]        hdr_phy;
  logic [4:0]        hdr_reg;
  logic              hdr_stb;
  logic              wr_stb;
  logic [15:0]       wr_data;
  logic [15:0]       rd_word16;
  logic [PAGE_W-1:0] page;
  acc_kind_e         kind;
  logic              half;
  logic              accept;
  logic [PAGE_W+8:0] map_addr;

  mdio_frame_rx #(.PRE_LEN(PRE_LEN)) rx_i (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(mdio_i),
    .accept(accept), .rd_word16(rd_word16),
    .hdr_op(hdr_op), .hdr_phy(hdr_phy), .hdr_reg(hdr_reg),
    .hdr_stb(hdr_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mdio_addr_map #(.PAGE_W(PAGE_W), .PHY_BASE(PHY_BASE), .PAGE_PHY(PAGE_PHY)) map_i (
    .op(hdr_op), .phy(hdr_phy), .regn(hdr_reg), .page(page),
    .kind(kind), .half(half), .accept(accept), .addr(map_addr)
  );

  mdio_word_engine #(.PAGE_W(PAGE_W), .ID_VALUE(ID_VALUE)) eng_i (
    .clk(clk), .rst(rst), .hdr_stb(hdr_stb), .wr_stb(wr_stb),
    .hdr_op(hdr_op), .kind(kind), .half(half), .addr(map_addr),
    .wr_data(wr_data), .rd_word16(rd_word16), .page(page),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk
  import mdio_bridge_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      mdio_o,
  input logic      mdio_oe,
  input logic      bus_we,
  input logic      bus_re,
  input logic      hdr_stb,
  input logic      wr_stb,
  input acc_kind_e kind
);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));

  p_we_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> !bus_we);

  p_we_after_frame_r5: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> $past(wr_stb));

  p_re_after_hdr_r6: assert property (@(posedge clk) disable iff (rst)
    bus_re |-> $past(hdr_stb));

  p_re_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> !bus_re);

  p_ta_zero_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o);

  p_quiet_while_drive_r9: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> (!bus_we && !bus_re));

  p_ignored_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (hdr_stb && kind == ACC_NONE) |=> !bus_re);
endmodule

bind mdio_page_bridge mdio_page_bridge_chk chk_i (
  .clk(clk), .rst(rst), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .bus_we(bus_we), .bus_re(bus_re), .hdr_stb(hdr_stb),
  .wr_stb(wr_stb), .kind(kind)
);

// File: tb/mdio_page_bridge_tb.sv
module mdio_page_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_MDC   = 8;
  localparam int AW         = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mdc = 1'b0;
  logic          m_en = 1'b0;
  logic          m_val = 1'b1;
  logic          line;
  logic          mdio_o, mdio_oe, bus_we, bus_re;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [31:0]   salt = 32'h0;
  int            we_cnt, re_cnt;
  logic [AW-1:0] last_wa;
  logic [31:0]   last_wd;
  int            n_cmp = 0;
  int            n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign line = m_en ? m_val : (mdio_oe ? mdio_o : 1'b1);

  mdio_page_bridge dut_i (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] mem_val(input logic [AW-1:0] a);
    return {a[17:2], a[15:0]} ^ 32'hA5C3_5A3C;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [8:0] pg, input logic [4:0] phy,
                                             input logic [4:0] r);
    return {pg, phy[2:0], r[4:1], 2'b00};
  endfunction

  // bus slave model: data registered one cycle after the read strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      we_cnt <= 0;
      re_cnt <= 0;
      last_wa <= '0;
      last_wd <= '0;
    end else begin
      if (bus_re) begin
        bus_rdata <= mem_val(bus_addr) ^ salt;
        re_cnt <= re_cnt + 1;
      end
      if (bus_we) begin
        we_cnt <= we_cnt + 1;
        last_wa <= bus_addr;
        last_wd <= bus_wdata;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mbit(input logic b, input logic en, output logic s_oe, output logic s_o);
    mdc = 1'b0;
    m_en = en;
    m_val = b;
    repeat (HALF_MDC) @(negedge clk);
    s_oe = mdio_oe;
    s_o = mdio_o;
    mdc = 1'b1;
    repeat (HALF_MDC) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic a, b;
    for (int i = n - 1; i >= 0; i--) mbit(v[i], 1'b1, a, b);
  endtask

  task automatic ones(input int n);
    logic a, b;
    for (int i = 0; i < n; i++) mbit(1'b1, 1'b1, a, b);
  endtask

  task automatic wr_raw(input int pre, input logic [1:0] op, input logic [4:0] phy,
                        input logic [4:0] r, input logic [15:0] d);
    ones(pre);
    send(32'h1, 2);
    send(32'(op), 2);
    send(32'(phy), 5);
    send(32'(r), 5);
    send(32'h2, 2);
    send(32'(d), 16);
    m_en = 1'b0;
    mdc = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] r, input logic [15:0] d);
    wr_raw(32, 2'b01, phy, r, d);
  endtask

  task automatic rd(input logic [4:0] phy, input logic [4:0] r, output logic [15:0] d,
                    output logic ta1_z, output logic ta2_z, output int drv);
    logic so, sv;
    ones(32);
    send(32'h1, 2);
    send(32'h2, 2);
    send(32'(phy), 5);
    send(32'(r), 5);
    d = '0;
    drv = 0;
    ta1_z = 1'b0;
    ta2_z = 1'b0;
    for (int i = 0; i < 18; i++) begin
      mbit(1'b1, 1'b0, so, sv);
      if (so) drv++;
      if (i == 0) ta1_z = !so;
      else if (i == 1) ta2_z = so && !sv;
      else d = {d[14:0], sv};
    end
    m_en = 1'b0;
    mdc = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d, hi, lo;
    logic t1, t2;
    int drv, we0, re0;
    logic [8:0] pg;
    logic [4:0] phy, r;
    logic [AW-1:0] a;
    logic [31:0] expw;
    void'($urandom(32'd77031));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oe", 32'(mdio_oe), 0);
    chk("R1 we/re", 32'({bus_we, bus_re}), 0);
    rd(5'h18, 5'd0, d, t1, t2, drv);
    chk("R1 page after reset", 32'(d), 0);

    // identification word, also the turnaround shape
    re0 = re_cnt;
    rd(5'h10, 5'd0, d, t1, t2, drv);
    chk("R7 id low", 32'(d), 32'h0101);
    chk("R8 ta1 undriven", 32'(t1), 1);
    chk("R8 ta2 zero", 32'(t2), 1);
    chk("R8 driven bit count", 32'(drv), 17);
    chk("R8 released", 32'(mdio_oe), 0);
    rd(5'h10, 5'd1, d, t1, t2, drv);
    chk("R7 id high", 32'(d), 0);
    chk("R7 no bus read", 32'(re_cnt - re0), 0);

    // page register
    wr(5'h18, 5'd0, 16'hFFAB);
    rd(5'h18, 5'd0, d, t1, t2, drv);
    chk("R3 page readback", 32'(d), 32'h01AB);

    // directed write pair
    we0 = we_cnt;
    wr(5'h15, 5'h0B, 16'hBEEF);
    chk("R5 high half no strobe", 32'(we_cnt - we0), 0);
    wr(5'h15, 5'h0A, 16'h1234);
    chk("R5 one strobe", 32'(we_cnt - we0), 1);
    chk("R4 write addr", 32'(last_wa), 32'(exp_addr(9'h1AB, 5'h15, 5'h0A)));
    chk("R5 write data", last_wd, 32'hBEEF_1234);

    // directed read pair with data changed between halves
    re0 = re_cnt;
    a = exp_addr(9'h1AB, 5'h13, 5'h06);
    expw = mem_val(a) ^ salt;
    rd(5'h13, 5'h06, d, t1, t2, drv);
    chk("R6 low half", 32'(d), 32'(expw[15:0]));
    salt = 32'hFFFF_FFFF;
    rd(5'h13, 5'h07, d, t1, t2, drv);
    chk("R6 high half same fetch", 32'(d), 32'(expw[31:16]));
    chk("R6 one bus read", 32'(re_cnt - re0), 1);

    // ignored frames
    we0 = we_cnt;
    re0 = re_cnt;
    wr(5'h05, 5'd0, 16'h5555);
    wr_raw(32, 2'b11, 5'h10, 5'd2, 16'h6666);
    wr_raw(32, 2'b00, 5'h10, 5'd2, 16'h6666);
    wr(5'h18, 5'd2, 16'h0033);
    chk("R9 no write strobe", 32'(we_cnt - we0), 0);
    rd(5'h1F, 5'd0, d, t1, t2, drv);
    chk("R9 no drive", 32'(drv), 0);
    rd(5'h09, 5'd2, d, t1, t2, drv);
    chk("R9 no drive low phy", 32'(drv), 0);
    chk("R9 no read strobe", 32'(re_cnt - re0), 0);
    rd(5'h18, 5'd0, d, t1, t2, drv);
    chk("R9 page unchanged", 32'(d), 32'h01AB);

    // preamble length
    send(32'h0, 4);
    wr_raw(31, 2'b01, 5'h18, 5'd0, 16'h0055);
    rd(5'h18, 5'd0, d, t1, t2, drv);
    chk("R2 short preamble ignored", 32'(d), 32'h01AB);
    wr_raw(40, 2'b01, 5'h18, 5'd0, 16'h0055);
    rd(5'h18, 5'd0, d, t1, t2, drv);
    chk("R2 long preamble accepted", 32'(d), 32'h0055);

    // random traffic
    for (int k = 0; k < 10; k++) begin
      pg = 9'($urandom);
      if (pg == 0) pg = 9'h101;
      phy = 5'h10 | 5'($urandom % 8);
      r = 5'($urandom % 16) << 1;
      hi = 16'($urandom);
      lo = 16'($urandom);
      wr(5'h18, 5'd0, 16'(pg));
      we0 = we_cnt;
      wr(phy, r | 5'd1, hi);
      wr(phy, r, lo);
      chk("R5 rand strobe", 32'(we_cnt - we0), 1);
      chk("R4 rand addr", 32'(last_wa), 32'(exp_addr(pg, phy, r)));
      chk("R5 rand data", last_wd, {hi, lo});
      re0 = re_cnt;
      expw = mem_val(exp_addr(pg, phy, r)) ^ salt;
      rd(phy, r, d, t1, t2, drv);
      chk("R6 rand low", 32'(d), 32'(expw[15:0]));
      salt = 32'($urandom);
      rd(phy, r | 5'd1, d, t1, t2, drv);
      chk("R6 rand high", 32'(d), 32'(expw[31:16]));
      chk("R6 rand reads", 32'(re_cnt - re0), 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule